// File: doc/BRIEF.md
# Core Isolation Test Wrapper

This block surrounds an embedded logic core so that the core can be scan-tested separately from the logic around it. Every combinational data terminal of the core gets an isolation cell built from one scan flip-flop and one multiplexer. Input cells sit between the external inputs and the core, and output cells sit between the core and the external outputs. The cells of each side form a surround chain. A three-bit serial test rail carries one chain per bit. Rail 0 runs through the input cells, rail 1 through the output cells, and rail 2 through the core's own internal scan chain. That internal chain is modelled here as a plain shift register. The core logic is modelled as `y = x XOR rotate_left_1(x)`.

A small control unit holds the wrapper mode as a state machine with three states:

- `ST_FUNC`: the cells are transparent.
- `ST_INWARD`: the input cells drive the core, and the output cells capture the core response.
- `ST_OUTWARD`: the output cells drive the external outputs, and the input cells capture what arrives from outside.

From any state, an update strobe moves the machine to the state decoded from the instruction register. Without the strobe it stays where it is. The instruction register is loaded serially and also holds one bypass select per rail. A bypassed rail passes through a single flip-flop instead of its chain. Each rail output is retimed on the falling test clock edge, which guards against hold-time skew at the next block.

Top module: `core_iso_wrapper`

## Requirements
- R1: After an asynchronous active-low reset, the following all read 0: every cell, every bypass flop, every core-chain flop, the instruction register and rail_out. The mode is functional.
- R2: In functional mode, func_out equals core(func_in), where core(x) bit i = x[i] XOR x[(i-1) mod W].
- R3: In inward mode, the core is fed from the input cells. func_out equals core(input cells), and func_in has no effect on func_out.
- R4: In outward mode, func_out equals the output cell contents, and the core output has no effect on func_out.
- R5: With scan_en low in a test mode, one rising edge performs a capture. The input cells load func_in, and the output cells load the core output computed from the value the core currently sees.
- R6: With scan_en high, every chain shifts one place per rising edge. Rail 0 enters input cell 0 and leaves from cell W-1. Rail 1 does the same through the output cells. Rail 2 passes through the CORE_CHAIN-long core chain.
- R7: Instruction bit 2+r set makes rail r a single flip-flop path loaded from rail_in[r] while scan_en is high.
- R8: rail_out changes only on the falling edge of tck. After a shift edge it shows the last flop of the selected path, and before that falling edge it still holds the old value.
- R9: The instruction register shifts right, with ir_si entering bit 4, while ir_shift is high. Bits [1:0] select the mode: 01 inward, 10 outward, 00 or 11 functional. Bits [4:2] are the bypass selects for rails 0 to 2. Mode and bypass change only on an edge with ir_update high.
- R10: In functional mode with scan_en low, all cells hold their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Shift enable for all rail chains |
| rail_in | input | 3 | Serial test rail inputs |
| rail_out | output | 3 | Serial test rail outputs, retimed on falling edge |
| func_in | input | W | External functional inputs |
| func_out | output | W | External functional outputs |
| ir_si | input | 1 | Instruction serial input |
| ir_shift | input | 1 | Instruction shift enable |
| ir_update | input | 1 | Instruction update strobe |

## Verification
The functional path is driven with patterns that have isolated, alternating and all-ones bits. Those patterns separate a correct neighbour XOR from a missing rotation or a reversed one. A continuity sequence, 11101000, is shifted on rail 2, with related but distinct streams on rails 0 and 1. This exposes swapped rails, wrong chain lengths and broken links. Inward and outward phases change func_in while the cells drive, to show that the external inputs cannot leak through. A capture followed by a scan-out tells apart whether a cell loaded the functional value or the core response. Bypass with a mixed select pattern checks that a rail shortens to one flop, and a sample taken before the falling edge checks the retiming.

// File: rtl/wrap_pkg.sv
package wrap_pkg;
    typedef enum logic [1:0] {
        ST_FUNC    = 2'd0,
        ST_INWARD  = 2'd1,
        ST_OUTWARD = 2'd2
    } wmode_e;

    localparam int RAILS = 3;
    localparam int IR_W  = 2 + RAILS;
endpackage

// File: rtl/wrap_ctrl.sv
module wrap_ctrl
    import wrap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ir_si,
    input  logic             ir_shift,
    input  logic             ir_update,
    output logic             in_drive,
    output logic             out_drive,
    output logic             test_act,
    output logic [RAILS-1:0] bypass_sel
);
    logic [IR_W-1:0]  ir_q;
    logic [RAILS-1:0] byp_q;
    wmode_e           state_q, state_d;

    function automatic wmode_e decode(input logic [1:0] code);
        unique case (code)
            2'b01:   return ST_INWARD;
            2'b10:   return ST_OUTWARD;
            default: return ST_FUNC;
        endcase
    endfunction

    // instruction shift path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ir_q <= '0;
        else if (ir_shift) ir_q <= {ir_si, ir_q[IR_W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         byp_q <= '0;
        else if (ir_update) byp_q <= ir_q[IR_W-1:2];
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FUNC;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FUNC:    if (ir_update) state_d = decode(ir_q[1:0]);
            ST_INWARD:  if (ir_update) state_d = decode(ir_q[1:0]);
            ST_OUTWARD: if (ir_update) state_d = decode(ir_q[1:0]);
            default:    state_d = ST_FUNC;
        endcase
    end

    // outputs
    always_comb begin
        in_drive   = 1'b0;
        out_drive  = 1'b0;
        test_act   = 1'b0;
        bypass_sel = byp_q;
        unique case (state_q)
            ST_FUNC: ;
            ST_INWARD: begin
                in_drive = 1'b1;
                test_act = 1'b1;
            end
            ST_OUTWARD: begin
                out_drive = 1'b1;
                test_act  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/wrap_surround.sv
module wrap_surround #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         cap_en,
    input  logic         si,
    input  logic [N-1:0] cap_d,
    output logic [N-1:0] cells,
    output logic         so
);
    logic [N:0] link;
    assign link[0] = si;

    for (genvar i = 0; i < N; i++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        cells[i] <= 1'b0;
            else if (shift_en) cells[i] <= link[i];
            else if (cap_en)   cells[i] <= cap_d[i];
        end
        assign link[i+1] = cells[i];
    end

    assign so = link[N];
endmodule

// File: rtl/core_model.sv
module core_model #(
    parameter int W  = 4,
    parameter int CL = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         se,
    input  logic         si,
    input  logic [W-1:0] d,
    output logic [W-1:0] y,
    output logic         so
);
    logic [CL-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  sr <= '0;
        else if (se) sr <= {sr[CL-2:0], si};
    end

    assign so = sr[CL-1];
    assign y  = d ^ {d[W-2:0], d[W-1]};
endmodule

// File: rtl/rail_tail.sv
module rail_tail (
    input  logic clk,
    input  logic rst_n,
    input  logic se,
    input  logic si,
    input  logic path,
    output logic byp_q,
    output logic rail_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  byp_q <= 1'b0;
        else if (se) byp_q <= si;
    end

    // anti-skew retiming on the falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) rail_o <= 1'b0;
        else        rail_o <= path;
    end
endmodule

// File: rtl/core_iso_wrapper.sv
module core_iso_wrapper
    import wrap_pkg::*;
#(
    parameter int W          = 4,
    parameter int CORE_CHAIN = 5
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             scan_en,
    input  logic [RAILS-1:0] rail_in,
    output logic [RAILS-1:0] rail_out,
    input  logic [W-1:0]     func_in,
    output logic [W-1:0]     func_out,
    input  logic             ir_si,
    input  logic             ir_shift,
    input  logic             ir_update
);
    logic             in_drive, out_drive, test_act, cap_en;
    logic [RAILS-1:0] bypass_sel, chain_so, byp_q, tail_path;
    logic [W-1:0]     icell, ocell, to_core, core_y;

    wrap_ctrl u_ctrl (
        .clk        (tck),
        .rst_n      (rst_n),
        .ir_si      (ir_si),
        .ir_shift   (ir_shift),
        .ir_update  (ir_update),
        .in_drive   (in_drive),
        .out_drive  (out_drive),
        .test_act   (test_act),
        .bypass_sel (bypass_sel)
    );

    assign cap_en = test_act & ~scan_en;

    wrap_surround #(.N(W)) u_in_cells (
        .clk      (tck),
        .rst_n    (rst_n),
        .shift_en (scan_en),
        .cap_en   (cap_en),
        .si       (rail_in[0]),
        .cap_d    (func_in),
        .cells    (icell),
        .so       (chain_so[0])
    );

    assign to_core = in_drive ? icell : func_in;

    core_model #(.W(W), .CL(CORE_CHAIN)) u_core (
        .clk   (tck),
        .rst_n (rst_n),
        .se    (scan_en),
        .si    (rail_in[2]),
        .d     (to_core),
        .y     (core_y),
        .so    (chain_so[2])
    );

    wrap_surround #(.N(W)) u_out_cells (
        .clk      (tck),
        .rst_n    (rst_n),
        .shift_en (scan_en),
        .cap_en   (cap_en),
        .si       (rail_in[1]),
        .cap_d    (core_y),
        .cells    (ocell),
        .so       (chain_so[1])
    );

    assign func_out = out_drive ? ocell : core_y;

    for (genvar r = 0; r < RAILS; r++) begin : g_rail
        assign tail_path[r] = bypass_sel[r] ? byp_q[r] : chain_so[r];
        rail_tail u_tail (
            .clk    (tck),
            .rst_n  (rst_n),
            .se     (scan_en),
            .si     (rail_in[r]),
            .path   (tail_path[r]),
            .byp_q  (byp_q[r]),
            .rail_o (rail_out[r])
        );
    end
endmodule

// File: rtl/wrap_checker.sv
module wrap_checker #(
    parameter int W = 4
) (
    input logic         tck,
    input logic         rst_n,
    input logic         scan_en,
    input logic [2:0]   rail_in,
    input logic [2:0]   rail_out,
    input logic [2:0]   tail_path,
    input logic [W-1:0] func_in,
    input logic [W-1:0] icell,
    input logic [W-1:0] ocell,
    input logic [W-1:0] core_y,
    input logic         in_drive,
    input logic         out_drive,
    input logic         ir_update
);
    assert_mode_hold_R9: assert property (@(posedge tck) disable iff (!rst_n)
        !ir_update |=> $stable({in_drive, out_drive}));

    assert_shift_entry_R6: assert property (@(posedge tck) disable iff (!rst_n)
        scan_en |=> icell[0] == $past(rail_in[0]));

    assert_capture_inward_R5: assert property (@(posedge tck) disable iff (!rst_n)
        (in_drive && !scan_en) |=> ocell == $past(core_y));

    assert_capture_outward_R5: assert property (@(posedge tck) disable iff (!rst_n)
        (out_drive && !scan_en) |=> icell == $past(func_in));

    assert_func_hold_R10: assert property (@(posedge tck) disable iff (!rst_n)
        (!in_drive && !out_drive && !scan_en) |=> ($stable(icell) && $stable(ocell)));

    assert_antiskew_R8: assert property (@(posedge tck) disable iff (!rst_n)
        rail_out == tail_path);

    assert_one_mode_R9: assert property (@(posedge tck) disable iff (!rst_n)
        $onehot0({in_drive, out_drive}));
endmodule

bind core_iso_wrapper wrap_checker #(.W(W)) u_wrap_chk (
    .tck       (tck),
    .rst_n     (rst_n),
    .scan_en   (scan_en),
    .rail_in   (rail_in),
    .rail_out  (rail_out),
    .tail_path (tail_path),
    .func_in   (func_in),
    .icell     (icell),
    .ocell     (ocell),
    .core_y    (core_y),
    .in_drive  (in_drive),
    .out_drive (out_drive),
    .ir_update (ir_update)
);

// File: tb/core_iso_wrapper_bench.sv
module core_iso_wrapper_bench;
    localparam int W  = 4;
    localparam int CL = 5;

    logic         tck = 1'b0, rst_n = 1'b0, scan_en = 1'b0;
    logic         ir_si = 1'b0, ir_shift = 1'b0, ir_update = 1'b0;
    logic [2:0]   rail_in = '0;
    logic [2:0]   rail_out;
    logic [W-1:0] func_in = '0;
    logic [W-1:0] func_out;

    core_iso_wrapper #(.W(W), .CORE_CHAIN(CL)) u_core_iso_wrapper (
        .tck(tck), .rst_n(rst_n), .scan_en(scan_en), .rail_in(rail_in),
        .rail_out(rail_out), .func_in(func_in), .func_out(func_out),
        .ir_si(ir_si), .ir_shift(ir_shift), .ir_update(ir_update)
    );

    always #10 tck = ~tck;   // 50 MHz

    int cyc = 0;
    always @(posedge tck) cyc <= cyc + 1;

    typedef struct {
        int         due;
        bit         kind;   // 0: rail_out, 1: func_out
        logic [3:0] exp;
        string      tag;
    } item_t;
    item_t q[$];

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    string phase_tag = "R1";

    // reference model state
    logic [W-1:0]  mi = '0, mo = '0;
    logic [CL-1:0] mc = '0;
    logic [2:0]    mb = '0, mbyp = '0;
    logic [4:0]    mir = '0;
    int            mmode = 0;

    function automatic logic [W-1:0] fcore(input logic [W-1:0] x);
        return x ^ {x[W-2:0], x[W-1]};
    endfunction

    function automatic logic [2:0] exp_rail();
        return {mbyp[2] ? mb[2] : mc[CL-1],
                mbyp[1] ? mb[1] : mo[W-1],
                mbyp[0] ? mb[0] : mi[W-1]};
    endfunction

    function automatic logic [W-1:0] exp_out();
        if (mmode == 1) return fcore(mi);
        if (mmode == 2) return mo;
        return fcore(func_in);
    endfunction

    task automatic push(input bit kind, input logic [3:0] e, input int due);
        item_t it;
        it.due = due; it.kind = kind; it.exp = e; it.tag = phase_tag;
        q.push_back(it);
    endtask

    task automatic check(input string tag, input logic [3:0] got, input logic [3:0] e);
        n_chk++;
        if (got !== e) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, got, e);
        end
    endtask

    // monitor
    initial forever begin
        @(posedge tck);
        #15;
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            it = q.pop_front();
            if (it.kind) check(it.tag, func_out, it.exp);
            else         check(it.tag, {1'b0, rail_out}, it.exp);
        end
    end

    task automatic chk_func();
        push(1'b1, exp_out(), cyc);
    endtask

    // one clock: advance model, push expected rail value, wait to next drive point
    task automatic tick();
        logic [W-1:0] ci, nmo;
        if (scan_en) begin
            mi = {mi[W-2:0], rail_in[0]};
            mo = {mo[W-2:0], rail_in[1]};
            mc = {mc[CL-2:0], rail_in[2]};
            mb = rail_in;
        end else if (mmode != 0) begin
            ci  = (mmode == 1) ? mi : func_in;
            nmo = fcore(ci);
            mi  = func_in;
            mo  = nmo;
        end
        if (ir_update) begin
            mmode = (mir[1:0] == 2'b01) ? 1 : (mir[1:0] == 2'b10) ? 2 : 0;
            mbyp  = mir[4:2];
        end else if (ir_shift) begin
            mir = {ir_si, mir[4:1]};
        end
        if (scan_en) push(1'b0, {1'b0, exp_rail()}, cyc + 1);
        @(posedge tck);
        #5;
    endtask

    task automatic ir_load(input logic [4:0] v, input bit peek);
        for (int k = 0; k < 5; k++) begin
            ir_si = v[k]; ir_shift = 1'b1;
            tick();
        end
        ir_shift = 1'b0;
        if (peek) begin
            phase_tag = "R9 no effect before update";
            func_in = 4'b1001;
            chk_func();
        end
        ir_update = 1'b1;
        tick();
        ir_update = 1'b0;
    endtask

    task automatic shift_n(input int n, input logic [2:0] seed);
        scan_en = 1'b1;
        for (int k = 0; k < n; k++) begin
            rail_in = seed ^ k[2:0];
            tick();
        end
        scan_en = 1'b0;
    endtask

    // watchdog
    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] pat;
        logic       old0;
        repeat (3) @(posedge tck);
        #5;
        rst_n = 1'b1;
        // R1 reset state
        check("R1 rail_out", {1'b0, rail_out}, 4'b0);
        check("R1 func_out", func_out, fcore(func_in));

        // R2 functional patterns
        phase_tag = "R2 functional";
        foreach (pat[i]) ;
        begin
            logic [W-1:0] pats [5] = '{4'b0000, 4'b0001, 4'b1010, 4'b1111, 4'b0110};
            foreach (pats[i]) begin
                func_in = pats[i];
                chk_func();
                tick();
            end
        end

        // R6 continuity
        phase_tag = "R6 continuity";
        pat = 8'b11101000;
        scan_en = 1'b1;
        for (int k = 0; k < 13; k++) begin
            logic b;
            b = (k < 8) ? pat[7-k] : 1'b0;
            rail_in = {b, b ^ k[0], ~b};
            tick();
        end
        scan_en = 1'b0;

        // R3 inward
        ir_load(5'b00001, 1'b1);
        phase_tag = "R3 inward";
        func_in = 4'b1111; chk_func(); tick();
        func_in = 4'b0000; chk_func(); tick();
        phase_tag = "R5 inward capture";
        func_in = 4'b0011; tick();
        shift_n(W + 1, 3'b010);

        // R4 outward
        ir_load(5'b00010, 1'b0);
        phase_tag = "R4 outward";
        func_in = 4'b0101; chk_func(); tick();
        func_in = 4'b1010; chk_func(); tick();
        phase_tag = "R5 outward capture";
        func_in = 4'b1100; tick();
        shift_n(W + 1, 3'b101);

        // R7 bypass on rails 0 and 2
        ir_load(5'b10100, 1'b0);
        phase_tag = "R7 bypass";
        shift_n(6, 3'b011);

        // R8 anti-skew: old value held until falling edge
        phase_tag = "R8 retime";
        scan_en = 1'b1;
        old0 = mb[0];
        rail_in = {3{~old0}};
        tick();
        check("R8 before falling edge", {3'b0, rail_out[0]}, {3'b0, old0});
        scan_en = 1'b0;

        // R9 code 11 is functional, bypass cleared
        ir_load(5'b00011, 1'b0);
        phase_tag = "R9 code 11 functional";
        func_in = 4'b0111; chk_func(); tick();

        // R10 functional hold
        phase_tag = "R10 hold";
        func_in = 4'b1110; tick();
        func_in = 4'b0001; tick();
        shift_n(CL + 1, 3'b110);

        repeat (3) @(posedge tck);
        #5;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule